// File: doc/BRIEF.md
# Pipelined multiply-accumulate unit

This block is a multiply-accumulate datapath that accepts one instruction on every clock. Each instruction multiplies two operands, either the full 32-bit words or only their low 16-bit halves. It then returns the product, adds the product to a 48-bit accumulator, subtracts it from that accumulator, or loads the accumulator with a new value. The operands can be read as signed integers, unsigned integers or signed fixed-point fractions. In fraction mode the product is shifted left by one bit so that the binary point lines up.

Execution passes through four register stages: operand preparation, multiply, alignment and accumulate. A result appears a fixed four clock edges after issue. The accumulator is read and written inside the last stage, so a chain of dependent accumulations can issue on consecutive cycles without stalling. A sticky overflow bit records any accumulation that leaves the 48-bit range for the signedness in use. A load instruction clears it, and the current accumulator can be read at any time on its own port.

Top module: `mac_pipe`

## Requirements
- R1: While rst_ni is low, and after its release until the first instruction completes, valid_o is 0, acc_o is 0 and ovf_o is 0.
- R2: An instruction sampled with issue_i=1 at clock edge k raises valid_o, with its result on result_o, right after edge k+3. One instruction may issue on every edge. result_o keeps its value until the next instruction completes.
- R3: With wide_i=0 only bits [15:0] of a_i and b_i are used, and bits [31:16] have no effect. With wide_i=1 all 32 bits are used.
- R4: fmt_i selects the format: 0 is a signed integer, 1 is an unsigned integer, 2 is a signed fraction, and 3 is treated as a signed integer. The aligned product is formed in one of three ways. For integer formats it is the low 48 bits of the product. For narrow fractions it is the product shifted left by 1. For wide fractions it is product bits [62:15], that is, the product shifted left by 1 and then right by 16.
- R5: op_i=0 sets result_o to the aligned product and leaves the accumulator unchanged. op_i=1 adds the aligned product to the accumulator. op_i=2 subtracts it. In both of these cases the new accumulator value is also placed on result_o.
- R6: op_i=3 loads the accumulator with acc_wdata_i, places that value on result_o and clears ovf_o. The write takes its place in program order with the other instructions.
- R7: Accumulations issued on consecutive edges each use the accumulator value left by the instruction before them, with no stall.
- R8: ovf_o is set when an add or subtract leaves the 48-bit range: signed for formats 0, 2 and 3, unsigned for format 1. It stays set until a load.
- R9: acc_o shows the committed accumulator, and it changes on the same edge that raises valid_o for the instruction that changes it.
- R10: An edge with issue_i=0 starts nothing, whatever the values on the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Starts an instruction on this edge |
| op_i | input | 2 | 0 multiply, 1 add-accumulate, 2 subtract-accumulate, 3 load |
| fmt_i | input | 2 | 0 signed int, 1 unsigned int, 2 signed fraction, 3 signed int |
| wide_i | input | 1 | 1 for 32x32, 0 for 16x16 on the low halves |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| acc_wdata_i | input | 48 | Value for a load instruction |
| valid_o | output | 1 | A result completes this cycle |
| result_o | output | 48 | Result of the last completed instruction |
| acc_o | output | 48 | Current accumulator |
| ovf_o | output | 1 | Sticky accumulation overflow |

## Verification
The bench builds the block with its default widths: 32-bit operands and a 48-bit accumulator. With these widths the wide fraction path drops exactly 16 low product bits, and the integer path truncates a 64-bit product to 48 bits. Corner operands such as the most negative word, all ones and the half-word limits therefore reach both the truncation and the signed and unsigned overflow edges of the accumulator. Unbroken runs of dependent accumulations exercise the forwarding at full rate.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_MAC  = 2'd1,
    OP_MSAC = 2'd2,
    OP_LOAD = 2'd3
  } mac_op_e;

  typedef enum logic [1:0] {
    FMT_SINT  = 2'd0,
    FMT_UINT  = 2'd1,
    FMT_SFRAC = 2'd2,
    FMT_RSVD  = 2'd3
  } mac_fmt_e;

  typedef struct packed {
    logic    vld;
    mac_op_e op;
    logic    uns;
    logic    frac;
    logic    wide;
  } mac_ctl_t;
endpackage

// File: rtl/mac_opnd.sv
`timescale 1ns/1ps
module mac_opnd #(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  input  logic            wide_i,
  input  logic            uns_i,
  output logic [OP_W:0]   a_ext_o,
  output logic [OP_W:0]   b_ext_o
);
  localparam int HALF = OP_W / 2;

  logic [1:0][OP_W-1:0] raw;
  logic [1:0][OP_W:0]   ext;

  assign raw[0] = a_i;
  assign raw[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    assign ext[g] = wide_i
      ? {~uns_i & raw[g][OP_W-1], raw[g]}
      : {{(HALF+1){~uns_i & raw[g][HALF-1]}}, raw[g][HALF-1:0]};
  end

  assign a_ext_o = ext[0];
  assign b_ext_o = ext[1];
endmodule

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
module mac_mult #(
  parameter int OP_W = 32,
  localparam int PROD_W = 2*OP_W + 2
) (
  input  logic [OP_W:0]          a_i,
  input  logic [OP_W:0]          b_i,
  output logic signed [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] a_s, b_s;
  assign a_s    = PROD_W'($signed(a_i));
  assign b_s    = PROD_W'($signed(b_i));
  assign prod_o = a_s * b_s;
endmodule

// File: rtl/mac_align.sv
`timescale 1ns/1ps
module mac_align #(
  parameter int OP_W  = 32,
  parameter int ACC_W = 48,
  localparam int PROD_W  = 2*OP_W + 2,
  localparam int FRAC_SH = 2*OP_W - ACC_W
) (
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic                     frac_i,
  input  logic                     wide_i,
  output logic [ACC_W-1:0]         aligned_o
);
  logic signed [PROD_W-1:0] dbl, sh;

  // fraction: restore binary point, wide form keeps the upper product bits
  assign dbl = frac_i ? (prod_i <<< 1) : prod_i;
  assign sh  = (frac_i && wide_i) ? (dbl >>> FRAC_SH) : dbl;
  assign aligned_o = ACC_W'(sh);
endmodule

// File: rtl/mac_accum.sv
`timescale 1ns/1ps
module mac_accum #(
  parameter int ACC_W = 48
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] addend_i,
  input  logic             sub_i,
  input  logic             uns_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             ovf_o
);
  logic [ACC_W:0] ext_sum;
  logic           s_acc, s_add, s_sum, sgn_ovf;

  assign ext_sum = sub_i ? ({1'b0, acc_i} - {1'b0, addend_i})
                         : ({1'b0, acc_i} + {1'b0, addend_i});
  assign sum_o = ext_sum[ACC_W-1:0];

  assign s_acc = acc_i[ACC_W-1];
  assign s_add = addend_i[ACC_W-1];
  assign s_sum = ext_sum[ACC_W-1];

  // signed: operands of agreeing effective sign, result sign flips
  assign sgn_ovf = (sub_i ? (s_acc != s_add) : (s_acc == s_add)) && (s_sum != s_acc);
  // unsigned: carry out on add, borrow on subtract
  assign ovf_o   = uns_i ? ext_sum[ACC_W] : sgn_ovf;
endmodule

// File: rtl/mac_pipe.sv
`timescale 1ns/1ps
module mac_pipe
  import mac_pkg::*;
#(
  parameter int OP_W  = 32,
  parameter int ACC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [1:0]       op_i,
  input  logic [1:0]       fmt_i,
  input  logic             wide_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic [ACC_W-1:0] acc_wdata_i,
  output logic             valid_o,
  output logic [ACC_W-1:0] result_o,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o
);
  localparam int PROD_W = 2*OP_W + 2;

  mac_ctl_t ctl_in, ctl1_q, ctl2_q, ctl3_q;
  logic [OP_W:0]   a_ext, b_ext, a1_q, b1_q;
  logic [ACC_W-1:0] wd1_q, wd2_q, wd3_q;
  logic signed [PROD_W-1:0] prod, prod2_q;
  logic [ACC_W-1:0] aligned, al3_q;
  logic [ACC_W-1:0] sum;
  logic             sum_ovf;
  logic [ACC_W-1:0] acc_q, acc_d, res_q, res_d;
  logic             ovf_q, ovf_d, vld_q;

  logic             commit_vld;
  mac_op_e          commit_op;
  logic [ACC_W-1:0] commit_wd;

  mac_fmt_e fmt_in;
  assign fmt_in = mac_fmt_e'(fmt_i);

  assign ctl_in.vld  = issue_i;
  assign ctl_in.op   = mac_op_e'(op_i);
  assign ctl_in.uns  = (fmt_in == FMT_UINT);
  assign ctl_in.frac = (fmt_in == FMT_SFRAC);
  assign ctl_in.wide = wide_i;

  // stage 1: operand select and extension
  mac_opnd #(.OP_W(OP_W)) u_opnd (
    .a_i     (a_i),
    .b_i     (b_i),
    .wide_i  (wide_i),
    .uns_i   (ctl_in.uns),
    .a_ext_o (a_ext),
    .b_ext_o (b_ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_q <= '0;
      a1_q   <= '0;
      b1_q   <= '0;
      wd1_q  <= '0;
    end else begin
      ctl1_q <= ctl_in;
      a1_q   <= a_ext;
      b1_q   <= b_ext;
      wd1_q  <= acc_wdata_i;
    end
  end

  // stage 2: multiply
  mac_mult #(.OP_W(OP_W)) u_mult (
    .a_i    (a1_q),
    .b_i    (b1_q),
    .prod_o (prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl2_q  <= '0;
      prod2_q <= '0;
      wd2_q   <= '0;
    end else begin
      ctl2_q  <= ctl1_q;
      prod2_q <= prod;
      wd2_q   <= wd1_q;
    end
  end

  // stage 3: binary point alignment
  mac_align #(.OP_W(OP_W), .ACC_W(ACC_W)) u_align (
    .prod_i    (prod2_q),
    .frac_i    (ctl2_q.frac),
    .wide_i    (ctl2_q.wide),
    .aligned_o (aligned)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl3_q <= '0;
      al3_q  <= '0;
      wd3_q  <= '0;
    end else begin
      ctl3_q <= ctl2_q;
      al3_q  <= aligned;
      wd3_q  <= wd2_q;
    end
  end

  // stage 4: accumulate against the live accumulator (implicit forwarding)
  assign commit_vld = ctl3_q.vld;
  assign commit_op  = ctl3_q.op;
  assign commit_wd  = wd3_q;

  mac_accum #(.ACC_W(ACC_W)) u_accum (
    .acc_i    (acc_q),
    .addend_i (al3_q),
    .sub_i    (commit_op == OP_MSAC),
    .uns_i    (ctl3_q.uns),
    .sum_o    (sum),
    .ovf_o    (sum_ovf)
  );

  always_comb begin
    acc_d = acc_q;
    ovf_d = ovf_q;
    res_d = res_q;
    if (commit_vld) begin
      unique case (commit_op)
        OP_MUL: res_d = al3_q;
        OP_MAC, OP_MSAC: begin
          acc_d = sum;
          res_d = sum;
          ovf_d = ovf_q | sum_ovf;
        end
        OP_LOAD: begin
          acc_d = commit_wd;
          res_d = commit_wd;
          ovf_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
      res_q <= res_d;
      vld_q <= commit_vld;
    end
  end

  assign valid_o  = vld_q;
  assign result_o = res_q;
  assign acc_o    = acc_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/mac_pipe_chk.sv
`timescale 1ns/1ps
module mac_pipe_chk
  import mac_pkg::*;
#(
  parameter int ACC_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_i,
  input logic             valid_o,
  input logic [ACC_W-1:0] acc_o,
  input logic             ovf_o,
  input logic             commit_vld,
  input mac_op_e          commit_op,
  input logic [ACC_W-1:0] commit_wd
);
  logic [2:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (!valid_o && acc_o == '0 && !ovf_o)
        else $error("R1 reset state");
    end
  end

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4) |-> (valid_o == $past(issue_i, 4)));

  a_r5_mul_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_vld && commit_op != OP_MUL) |=> $stable(acc_o));

  a_r6_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_vld && commit_op == OP_LOAD) |=> (acc_o == $past(commit_wd) && !ovf_o));

  a_r8_sticky_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !(commit_vld && commit_op == OP_LOAD)) |=> ovf_o);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_vld) |=> !valid_o);
endmodule

bind mac_pipe mac_pipe_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .issue_i    (issue_i),
  .valid_o    (valid_o),
  .acc_o      (acc_o),
  .ovf_o      (ovf_o),
  .commit_vld (commit_vld),
  .commit_op  (commit_op),
  .commit_wd  (commit_wd)
);

// File: tb/mac_pipe_bench.sv
`timescale 1ns/1ps
module mac_pipe_bench;
  localparam int OP_W  = 32;
  localparam int ACC_W = 48;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b1;
  logic             issue_i = 1'b0;
  logic [1:0]       op_i = '0;
  logic [1:0]       fmt_i = '0;
  logic             wide_i = 1'b0;
  logic [OP_W-1:0]  a_i = '0;
  logic [OP_W-1:0]  b_i = '0;
  logic [ACC_W-1:0] acc_wdata_i = '0;
  logic             valid_o;
  logic [ACC_W-1:0] result_o;
  logic [ACC_W-1:0] acc_o;
  logic             ovf_o;

  mac_pipe #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mac_pipe (
    .clk_i, .rst_ni, .issue_i, .op_i, .fmt_i, .wide_i, .a_i, .b_i,
    .acc_wdata_i, .valid_o, .result_o, .acc_o, .ovf_o
  );

  always #2 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string cur_tag = "R5";

  typedef struct {
    bit iss; bit [1:0] op; bit [1:0] fmt; bit wide;
    bit [31:0] a; bit [31:0] b; bit [47:0] wd;
  } ent_t;

  ent_t q[$];
  bit [47:0] m_acc, m_res;
  bit        m_ovf, m_valid;

  function automatic bit [47:0] m_align(bit [31:0] a, bit [31:0] b, bit [1:0] fmt, bit wide);
    logic signed [127:0] x, y, p;
    if (wide) begin
      x = (fmt == 2'd1) ? $signed({96'd0, a}) : 128'($signed(a));
      y = (fmt == 2'd1) ? $signed({96'd0, b}) : 128'($signed(b));
    end else begin
      x = (fmt == 2'd1) ? $signed({112'd0, a[15:0]}) : 128'($signed(a[15:0]));
      y = (fmt == 2'd1) ? $signed({112'd0, b[15:0]}) : 128'($signed(b[15:0]));
    end
    p = x * y;
    if (fmt == 2'd2) begin
      p = p <<< 1;
      if (wide) p = p >>> 16;
    end
    return p[47:0];
  endfunction

  task automatic m_apply(ent_t e);
    logic [47:0] al;
    logic signed [127:0] s, lim;
    logic [127:0] u;
    m_valid = e.iss;
    if (!e.iss) return;
    al = m_align(e.a, e.b, e.fmt, e.wide);
    case (e.op)
      2'd0: m_res = al;
      2'd3: begin m_acc = e.wd; m_res = e.wd; m_ovf = 0; end
      default: begin
        if (e.fmt == 2'd1) begin
          u = (e.op == 2'd2) ? ({80'd0, m_acc} - {80'd0, al}) : ({80'd0, m_acc} + {80'd0, al});
          if (u[127:48] != 0) m_ovf = 1;
          m_acc = u[47:0];
        end else begin
          lim = 128'sd140737488355328;
          s = (e.op == 2'd2) ? (128'($signed(m_acc)) - 128'($signed(al)))
                             : (128'($signed(m_acc)) + 128'($signed(al)));
          if (s >= lim || s < -lim) m_ovf = 1;
          m_acc = s[47:0];
        end
        m_res = m_acc;
      end
    endcase
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete();
      m_acc = '0; m_res = '0; m_ovf = 0; m_valid = 0;
    end else begin
      ent_t e;
      e.iss = issue_i; e.op = op_i; e.fmt = fmt_i; e.wide = wide_i;
      e.a = a_i; e.b = b_i; e.wd = acc_wdata_i;
      q.push_back(e);
      if (q.size() == 4) m_apply(q.pop_front());
      else m_valid = 0;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R2", 64'(valid_o), 64'(m_valid));
    if (m_valid) check(cur_tag, 64'(result_o), 64'(m_res));
    check("R9", 64'(acc_o), 64'(m_acc));
    check("R8", 64'(ovf_o), 64'(m_ovf));
  endtask

  task automatic step(bit iss, bit [1:0] op, bit [1:0] fmt, bit wide,
                      bit [31:0] a, bit [31:0] b, bit [47:0] wd);
    @(negedge clk_i);
    compare();
    issue_i = iss; op_i = op; fmt_i = fmt; wide_i = wide;
    a_i = a; b_i = b; acc_wdata_i = wd;
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, $urandom, $urandom, {$urandom, $urandom});
  endtask

  function automatic bit [31:0] pick();
    case ($urandom_range(0, 9))
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return {$urandom_range(0, 65535), 16'h8000};
      6: return {$urandom_range(0, 65535), 16'h7FFF};
      default: return $urandom;
    endcase
  endfunction

  function automatic bit [47:0] pick_wd();
    case ($urandom_range(0, 4))
      0: return 48'h7FFF_FFFF_FFFF;
      1: return 48'h8000_0000_0000;
      2: return 48'hFFFF_FFFF_FFFF;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1: reset state visible on the ports
    check("R1", 64'(valid_o), 64'd0);
    check("R1", 64'(acc_o), 64'd0);
    check("R1", 64'(ovf_o), 64'd0);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0);
    check("R1", 64'(valid_o), 64'd0);

    // R5: mixed random traffic, all ops and formats
    cur_tag = "R5";
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 4) != 0, 2'($urandom), 2'($urandom), 1'($urandom),
           pick(), pick(), pick_wd());
    drain();

    // R3: narrow multiply, upper halves ignored
    cur_tag = "R3";
    step(1, 3, 0, 0, 0, 0, 48'd0);
    step(1, 1, 0, 0, 32'hABCD_0003, 32'h9999_FFFB, 0);
    drain();
    check("R3", 64'(acc_o), 64'h0000_FFFF_FFFF_FFF1);
    for (int i = 0; i < 200; i++)
      step(1, 2'($urandom_range(0, 2)), 2'($urandom), 0, pick(), pick(), pick_wd());
    drain();

    // R4: wide fraction alignment, 0.5 * 0.5 -> 0.25
    cur_tag = "R4";
    step(1, 0, 2, 1, 32'h4000_0000, 32'h4000_0000, 0);
    drain();
    check("R4", 64'(result_o), 64'h0000_2000_0000_0000);
    step(1, 0, 2, 0, 32'h0000_4000, 32'h0000_4000, 0);
    drain();
    check("R4", 64'(result_o), 64'h0000_0000_2000_0000);
    for (int i = 0; i < 200; i++)
      step(1, 2'($urandom_range(0, 2)), 2'($urandom), 1'($urandom), pick(), pick(), 0);
    drain();

    // R7: dependent accumulations back to back
    cur_tag = "R7";
    step(1, 3, 0, 0, 0, 0, 48'd0);
    for (int i = 0; i < 10; i++) step(1, 1, 1, 1, 32'd3, 32'd7, 0);
    drain();
    check("R7", 64'(acc_o), 64'd210);

    // R8/R6: overflow sets, survives a multiply, load clears
    cur_tag = "R6";
    step(1, 3, 0, 0, 0, 0, 48'h7FFF_FFFF_FFFF);
    step(1, 1, 0, 1, 32'd1, 32'd1, 0);
    drain();
    check("R8", 64'(ovf_o), 64'd1);
    check("R8", 64'(acc_o), 64'h0000_8000_0000_0000);
    step(1, 0, 0, 1, 32'd2, 32'd2, 0);
    drain();
    check("R8", 64'(ovf_o), 64'd1);
    step(1, 3, 0, 0, 0, 0, 48'd5);
    drain();
    check("R6", 64'(ovf_o), 64'd0);
    check("R6", 64'(acc_o), 64'd5);
    // unsigned borrow
    step(1, 2, 1, 1, 32'd6, 32'd1, 0);
    drain();
    check("R8", 64'(ovf_o), 64'd1);

    // R10: issue low with busy inputs changes nothing
    cur_tag = "R10";
    for (int i = 0; i < 40; i++) step(0, 2'($urandom), 2'($urandom), 1'($urandom),
                                      $urandom, $urandom, {$urandom, $urandom});
    check("R10", 64'(acc_o), 64'h0000_FFFF_FFFF_FFFF);
    check("R10", 64'(valid_o), 64'd0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule